// File: doc/BRIEF.md
# Request/Grant Line Bus Handover Controller

This block runs the processor side of a bus handover with other bus masters over shared request/grant lines. Each line is active low and carries all three events of an exchange as one-clock pulses. The other master pulses the line to ask for the bus. The controller pulses the same line back to grant it. The other master pulses it a third time when it is done. Each line is modelled as an input level plus a pull-down enable, and the line is high whenever nobody pulls it. Line 0 wins over line 1 when both ask in the same clock.

The controller learns the phase of the current bus cycle from a 3-bit code and reads three flags that can block a handover. The flags mark the first half of a split word access at an odd address, a locked instruction, and the first interrupt-acknowledge cycle. It frees the bus at once when the bus is idle. During a memory cycle it frees the bus only at a T4 clock that the rules allow. While another master owns the bus, `bus_float_o` tells the bus drivers to let go. A one-clock `bus_resume_o` marks the clock in which the processor takes the bus back. That clock also serves as the dead clock between exchanges.

The state machine has five states:
- READY waits for a request. A valid request moves it to GRANT when release is allowed at once, and to PENDING otherwise.
- PENDING waits for an allowed release point and then moves to GRANT.
- GRANT drives the grant pulse for one clock and always moves to HELD.
- HELD floats the bus. A release pulse on the owning line moves it to RESUME.
- RESUME is the reclaim clock and the dead clock, and always returns to READY.

Top module: `bus_handover_ctl`

## Requirements
- R1: While reset is asserted, and directly after it, `line_pull`, `bus_float_o` and `bus_resume_o` are all 0.
- R2: A request counts only when a line (`line_in` bit, 1 = high) reads low for exactly one clock, with a high clock before it and a high clock after it. A line held low for two or more clocks causes no grant and no float.
- R3: If the clock after a valid request pulse carries phase code IDLE (`phase_i` = 0), the grant follows in the next clock. The grant is `line_pull` high on the requesting bit for exactly one clock.
- R4: The phase codes are T1 = 1, T2 = 2, T3 = 3, TW = 4 and T4 = 5. During memory cycles a grant is driven only in the clock after an IDLE clock or a T4 clock. A request pulsed in a T1 or T2 clock is granted right after the T4 of the same cycle.
- R5: A request pulsed in a T3, TW or T4 clock is too late for that cycle's release point. It is granted right after the T4 of the following cycle.
- R6: A T4 clock in which `odd_split_i`, `lock_i` or `inta_first_i` is 1 gives no grant. The request stays pending for the next eligible T4, and a block that repeats defers it again.
- R7: `bus_float_o` rises in the clock after the grant pulse. It stays high until the release is recognised.
- R8: A release pulse, one clock low on the owning line in a clock after the grant, ends the exchange. `bus_float_o` stays high through the clock that follows the pulse. In the clock after that, `bus_float_o` is 0 and `bus_resume_o` is 1 for exactly one clock.
- R9: The resume clock is the dead clock, with no grant and no float. A request pulsed in the clock after the resume clock is served under R3.
- R10: When both lines pulse a request in the same clock, line 0 is granted and line 1 is dropped.
- R11: Request pulses on the non-owning line are ignored from the moment a request is accepted until the exchange ends. They never lead to a grant on that line.
- R12: A pulse on the non-owning line while the bus is held neither ends the float nor causes a resume.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_CH | Sampled level of each request/grant line (1 = high) |
| line_pull | output | NUM_CH | Pull-down enable per line; 1 drives the line low |
| phase_i | input | 3 | Phase of the current clock: 0 IDLE, 1 T1, 2 T2, 3 T3, 4 TW, 5 T4 |
| odd_split_i | input | 1 | Current access is the first half of a split word at an odd address |
| lock_i | input | 1 | A locked instruction is executing |
| inta_first_i | input | 1 | Current cycle is the first interrupt-acknowledge cycle |
| bus_float_o | output | 1 | Bus drivers must float (another master owns the bus) |
| bus_resume_o | output | 1 | One-clock marker of the clock in which the bus is taken back |

## Verification
The bench sweeps the request clock across every position of memory cycles of four, five and six clocks. A design that misjudged lateness would grant at the wrong T4, either one cycle early or one cycle late. It places each blocking flag on the deciding T4, and a design that ignored one would grant four clocks early. It sends pulses of two to four clocks, which a plain edge detector would wrongly accept. It also pulses the non-owning line while a request is pending and while the bus is held. A design that let that line through would grant twice, or end the float early with the wrong master still on the bus. It runs back-to-back exchanges to catch a dead clock that is missing or swallows a request.

// File: rtl/bho_pkg.sv
package bho_pkg;
    localparam int PH_W = 3;

    typedef enum logic [PH_W-1:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } bus_phase_e;

    typedef enum logic [2:0] {
        S_READY   = 3'd0,
        S_PENDING = 3'd1,
        S_GRANT   = 3'd2,
        S_HELD    = 3'd3,
        S_RESUME  = 3'd4
    } hs_state_e;

    // A request pulsed after T2 has missed the release point of its cycle.
    function automatic logic phase_after_t2(input logic [PH_W-1:0] ph);
        return (ph == PH_T3) || (ph == PH_TW);
    endfunction
endpackage

// File: rtl/bho_pulse_detect.sv
module bho_pulse_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic line_hi,
    output logic pulse
);
    logic hist1_q;
    logic hist2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist1_q <= 1'b1;
            hist2_q <= 1'b1;
        end else begin
            hist1_q <= line_hi;
            hist2_q <= hist1_q;
        end
    end

    // high, then exactly one low clock, then high again
    always_comb begin
        pulse = line_hi & ~hist1_q & hist2_q;
    end
endmodule

// File: rtl/bho_prio_pick.sv
module bho_prio_pick #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic [NUM_CH-1:0] req,
    output logic              any,
    output logic [CH_W-1:0]   idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = CH_W'(i);
            end
        end
    end
endmodule

// File: rtl/bho_release_gate.sv
module bho_release_gate
    import bho_pkg::*;
(
    input  logic [PH_W-1:0] phase,
    input  logic            late,
    input  logic            odd_split,
    input  logic            locked,
    input  logic            inta_first,
    output logic            ok,
    output logic            at_t4
);
    logic at_idle;
    logic blocked;

    always_comb begin
        at_idle = (phase == PH_IDLE);
        at_t4   = (phase == PH_T4);
        blocked = late | odd_split | locked | inta_first;
        ok      = at_idle | (at_t4 & ~blocked);
    end
endmodule

// File: rtl/bus_handover_ctl.sv
module bus_handover_ctl
    import bho_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] line_in,
    output logic [NUM_CH-1:0] line_pull,
    input  logic [PH_W-1:0]   phase_i,
    input  logic              odd_split_i,
    input  logic              lock_i,
    input  logic              inta_first_i,
    output logic              bus_float_o,
    output logic              bus_resume_o
);
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    hs_state_e       state_q, state_d;
    logic [CH_W-1:0] owner_q, owner_d;
    logic            late_q, late_d;
    logic [PH_W-1:0] phase_prev_q;

    logic [NUM_CH-1:0] seen;
    logic              any_req;
    logic [CH_W-1:0]   pick_idx;
    logic              late_now;
    logic              late_sel;
    logic              rel_ok;
    logic              rel_t4;

    // one pulse detector per line; own drive is masked out of the level
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_line
            logic lvl;
            assign lvl = line_in[g] | line_pull[g];
            bho_pulse_detect u_det (
                .clk     (clk),
                .rst_n   (rst_n),
                .line_hi (lvl),
                .pulse   (seen[g])
            );
        end
    endgenerate

    bho_prio_pick #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_pick (
        .req (seen),
        .any (any_req),
        .idx (pick_idx)
    );

    always_comb begin
        late_now = phase_after_t2(phase_prev_q);
        late_sel = (state_q == S_READY) ? late_now : late_q;
    end

    bho_release_gate u_gate (
        .phase      (phase_i),
        .late       (late_sel),
        .odd_split  (odd_split_i),
        .locked     (lock_i),
        .inta_first (inta_first_i),
        .ok         (rel_ok),
        .at_t4      (rel_t4)
    );

    // next state
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        late_d  = late_q;
        unique case (state_q)
            S_READY: begin
                if (any_req) begin
                    owner_d = pick_idx;
                    late_d  = late_now;
                    if (rel_ok) begin
                        state_d = S_GRANT;
                    end else begin
                        state_d = S_PENDING;
                        if (rel_t4) begin
                            late_d = 1'b0;
                        end
                    end
                end
            end
            S_PENDING: begin
                if (rel_ok) begin
                    state_d = S_GRANT;
                end else if (rel_t4) begin
                    late_d = 1'b0;
                end
            end
            S_GRANT: begin
                state_d = S_HELD;
            end
            S_HELD: begin
                if (seen[owner_q]) begin
                    state_d = S_RESUME;
                end
            end
            S_RESUME: begin
                state_d = S_READY;
            end
            default: begin
                state_d = S_READY;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= S_READY;
            owner_q      <= '0;
            late_q       <= 1'b0;
            phase_prev_q <= PH_IDLE;
        end else begin
            state_q      <= state_d;
            owner_q      <= owner_d;
            late_q       <= late_d;
            phase_prev_q <= phase_i;
        end
    end

    // outputs
    always_comb begin
        line_pull    = '0;
        bus_float_o  = 1'b0;
        bus_resume_o = 1'b0;
        unique case (state_q)
            S_GRANT:  line_pull[owner_q] = 1'b1;
            S_HELD:   bus_float_o        = 1'b1;
            S_RESUME: bus_resume_o       = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/bus_handover_chk.sv
module bus_handover_chk
    import bho_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] line_pull,
    input logic [PH_W-1:0]   phase_i,
    input logic              odd_split_i,
    input logic              lock_i,
    input logic              inta_first_i,
    input logic              bus_float_o,
    input logic              bus_resume_o
);
    AST_GRANT_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_pull) |=> !(|line_pull)); // R3

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line_pull)); // R10

    AST_FLOAT_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_pull) |=> bus_float_o); // R7

    AST_GRANT_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        (|line_pull) |-> ($past(phase_i) == PH_IDLE || $past(phase_i) == PH_T4)); // R4

    AST_T4_UNBLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ((|line_pull) && $past(phase_i) == PH_T4)
            |-> !($past(lock_i) || $past(odd_split_i) || $past(inta_first_i))); // R6

    AST_RESUME_FROM_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_resume_o |-> $past(bus_float_o)); // R8

    AST_DEAD_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_resume_o |=> (!bus_resume_o && !bus_float_o && !(|line_pull))); // R9
endmodule

bind bus_handover_ctl bus_handover_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_pull    (line_pull),
    .phase_i      (phase_i),
    .odd_split_i  (odd_split_i),
    .lock_i       (lock_i),
    .inta_first_i (inta_first_i),
    .bus_float_o  (bus_float_o),
    .bus_resume_o (bus_resume_o)
);

// File: tb/bus_handover_ctl_bench.sv
module bus_handover_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pull_ext = 2'b00;
    logic [1:0] line_in;
    logic [1:0] line_pull;
    logic [2:0] phase = 3'd0;
    logic       odd = 1'b0, lck = 1'b0, inta = 1'b0;
    logic       bus_float_o, bus_resume_o;

    int checks = 0;
    int errors = 0;
    int ncyc = 0;
    int t0 = 0;
    bit done = 0;

    bit g_seen, f_seen, r_seen;
    int g_at, g_ch, g_cnt, g_last_at, g_last_ch, f_at, f_cnt, r_at, r_cnt;

    always #4 clk = ~clk;

    assign line_in = ~(pull_ext | line_pull);

    bus_handover_ctl #(.NUM_CH(2)) u_bus_handover_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_in      (line_in),
        .line_pull    (line_pull),
        .phase_i      (phase),
        .odd_split_i  (odd),
        .lock_i       (lck),
        .inta_first_i (inta),
        .bus_float_o  (bus_float_o),
        .bus_resume_o (bus_resume_o)
    );

    always @(posedge clk) ncyc <= ncyc + 1;

    always @(negedge clk) begin
        if (|line_pull) begin
            g_cnt++;
            g_last_at = ncyc;
            g_last_ch = line_pull[1] ? 1 : 0;
            if (!g_seen) begin
                g_seen = 1;
                g_at = ncyc;
                g_ch = g_last_ch;
            end
        end
        if (bus_float_o) begin
            f_cnt++;
            if (!f_seen) begin
                f_seen = 1;
                f_at = ncyc;
            end
        end
        if (bus_resume_o) begin
            r_cnt++;
            if (!r_seen) begin
                r_seen = 1;
                r_at = ncyc;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic arm();
        g_seen = 0; f_seen = 0; r_seen = 0;
        g_at = -1; g_ch = -1; g_cnt = 0; g_last_at = -1; g_last_ch = -1;
        f_at = -1; f_cnt = 0; r_at = -1; r_cnt = 0;
        t0 = ncyc;
    endtask

    // relative step index whose edge produced a recorded event
    function automatic int rel(input int at);
        return (at < 0) ? -1 : at - t0 - 1;
    endfunction

    task automatic step(input logic [2:0] ph, input logic [1:0] pl,
                        input logic o, input logic l, input logic a);
        phase = ph; pull_ext = pl; odd = o; lck = l; inta = a;
        @(negedge clk);
    endtask

    task automatic idle_steps(input int n);
        for (int i = 0; i < n; i++) step(3'd0, 2'b00, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [2:0] ph_at(input int s, input int len);
        int pos;
        pos = s % len;
        if (pos == 0) return 3'd1;
        if (pos == 1) return 3'd2;
        if (pos == 2) return 3'd3;
        if (pos == len - 1) return 3'd5;
        return 3'd4;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: quiet during and right after reset
        repeat (3) @(negedge clk);
        check("R1 pull in reset", int'(line_pull), 0);
        check("R1 float in reset", int'(bus_float_o), 0);
        check("R1 resume in reset", int'(bus_resume_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        idle_steps(2);
        check("R1 pull after reset", int'(line_pull), 0);
        check("R1 float after reset", int'(bus_float_o), 0);
        check("R1 resume after reset", int'(bus_resume_o), 0);

        // R3 R7 R8: idle-bus exchanges, both lines, several hold lengths
        for (int ch = 0; ch < 2; ch++) begin
            for (int hl = 0; hl < 5; hl++) begin
                arm();
                for (int s = 0; s < hl + 9; s++)
                    step(3'd0, (s == 0 || s == 3 + hl) ? 2'(1 << ch) : 2'b00, 1'b0, 1'b0, 1'b0);
                check("R3 idle grant clock", rel(g_at), 1);
                check("R3 idle grant line", g_ch, ch);
                check("R3 grant width", g_cnt, 1);
                check("R7 float start", rel(f_at), 2);
                check("R7 float length", f_cnt, hl + 2);
                check("R8 resume clock", rel(r_at), hl + 4);
                check("R8 resume width", r_cnt, 1);
            end
        end

        // R4 R5: request position swept over memory cycles with 0..2 waits
        for (int w = 0; w < 3; w++) begin
            for (int p = 0; p < 2 * (4 + w); p++) begin
                int len, gexp, ch;
                len = 4 + w;
                ch = p % 2;
                gexp = (p / len) * len + len - 1 + (((p % len) >= 2) ? len : 0);
                arm();
                for (int s = 0; s < gexp + 7; s++)
                    step(ph_at(s, len), (s == p || s == gexp + 2) ? 2'(1 << ch) : 2'b00,
                         1'b0, 1'b0, 1'b0);
                if ((p % len) < 2)
                    check("R4 on-time grant clock", rel(g_at), gexp);
                else
                    check("R5 late grant clock", rel(g_at), gexp);
                check("R4 grant line", g_ch, ch);
                check("R8 resume after mem grant", rel(r_at), gexp + 3);
                idle_steps(2);
            end
        end

        // R6: each blocking flag on the deciding T4, then a repeated lock
        for (int b = 0; b < 4; b++) begin
            int gexp;
            gexp = (b == 3) ? 11 : 7;
            arm();
            for (int s = 0; s < gexp + 7; s++)
                step(ph_at(s, 4), (s == 0 || s == gexp + 2) ? 2'b01 : 2'b00,
                     (b == 0 && s == 3),
                     (b == 1 && s == 3) || (b == 3 && s <= 7),
                     (b == 2 && s == 3));
            check("R6 blocked T4 defers grant", rel(g_at), gexp);
            check("R6 single grant", g_cnt, 1);
            idle_steps(2);
        end

        // R2: pulses longer than one clock are not requests
        for (int wid = 2; wid < 5; wid++) begin
            arm();
            for (int s = 0; s < wid + 8; s++)
                step(3'd0, (s < wid) ? 2'(1 << (wid % 2)) : 2'b00, 1'b0, 1'b0, 1'b0);
            check("R2 long pulse no grant", g_cnt, 0);
            check("R2 long pulse no float", f_cnt, 0);
        end

        // R10 R11 R12: simultaneous requests, then the other line pulses while held
        arm();
        for (int s = 0; s < 15; s++)
            step(3'd0, (s == 0) ? 2'b11 : (s == 3) ? 2'b10 : (s == 5) ? 2'b01 : 2'b00,
                 1'b0, 1'b0, 1'b0);
        check("R10 line 0 wins", g_ch, 0);
        check("R10 grant clock", rel(g_at), 1);
        check("R11 no grant for other line", g_cnt, 1);
        check("R12 other line does not release", rel(r_at), 6);
        check("R12 float kept", f_cnt, 4);

        // R11: other line pulses while a request is pending in a memory cycle
        arm();
        for (int s = 0; s < 16; s++)
            step(ph_at(s, 4), (s == 0) ? 2'b01 : (s == 1) ? 2'b10 : (s == 5) ? 2'b01 : 2'b00,
                 1'b0, 1'b0, 1'b0);
        check("R11 pending grant line", g_ch, 0);
        check("R11 pending grant clock", rel(g_at), 3);
        check("R11 pending other ignored", g_cnt, 1);

        // R9: back-to-back exchange right after the dead clock
        arm();
        for (int s = 0; s < 15; s++)
            step(3'd0, (s == 0 || s == 3) ? 2'b01 : (s == 6 || s == 9) ? 2'b10 : 2'b00,
                 1'b0, 1'b0, 1'b0);
        check("R9 first resume clock", rel(r_at), 4);
        check("R9 second grant clock", rel(g_last_at), 7);
        check("R9 second grant line", g_last_ch, 1);
        check("R9 two grants", g_cnt, 2);
        check("R9 two resumes", r_cnt, 2);
        check("R9 float clocks", f_cnt, 4);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule